// File: doc/BRIEF.md
# Paired-Byte Wide Register Write Capture

This block sits on an 8-bit processor bus next to an existing register decoder that owns a window of sixteen byte-wide mapping registers. It keeps its own bank of sixteen 16-bit registers, one per window address. In compatible mode it behaves like a plain byte register file and never interferes with the legacy decoder. In wide mode it spots a 16-bit store, which the processor issues as two byte writes to adjacent addresses in consecutive bus cycles. It merges the two bytes into the 16-bit register at the lower address. It also raises an override during the second cycle so that the legacy decoder drops that write and the neighbouring register keeps its value.

A bus cycle ends on the falling edge of the E strobe. The block samples E with its own clock and treats each falling edge as the end of one bus cycle. Address, data and direction are captured while E is high. A write that might open a pair is held pending until the following bus cycle decides its fate. A single mode bit at a spare address outside the window selects the mode. It resets to compatible mode and can be observed on a port.

Top module: `wide_pair_capture`

## Requirements
- R1: The window is the sixteen addresses 0xFFA0..0xFFAF; register k belongs to address 0xFFA0+k (low four address bits). A write outside the window, other than to the mode address, or any read cycle, by itself changes no register.
- R2: In compatible mode a write of byte d to window address 0xFFA0+k sets bits [7:0] of register k to d and leaves bits [15:8] unchanged; `legacy_wr_block` is never asserted in this mode, not even for adjacent-address writes.
- R3: The mode bit is bit 0 of a write to address 0xFFEF (1 = wide, 0 = compatible). It is 0 after reset, is visible on `wide_mode`, and governs bus cycles that start after the writing cycle ends.
- R4: In wide mode a write of byte h to 0xFFA0+k, followed on the very next bus cycle by a write of byte l to the next address, sets register k to {h, l} (h in bits [15:8]).
- R5: During the second write of such a pair, `legacy_wr_block` is 1 while E is high, and the register belonging to that second address is not changed. A read to the next address asserts no override.
- R6: A pair that starts at 0xFFAF completes with a write to 0xFFB0; that second cycle is overridden the same way.
- R7: In wide mode, if the bus cycle after a window write is not a write to the next address (a read, another address, the same address, a lower address, or a mode write), the first byte is written to bits [7:0] of its register at the end of that following cycle, with no override.
- R8: Once a pair completes, nothing stays pending: a further write to the address after the pair starts a new pair rather than joining the old one.
- R9: All registers read 0 after reset, and registers and the mode bit change only at the end of a bus cycle (the falling edge of E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the E strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_e | input | 1 | Bus E strobe; a cycle ends on its falling edge |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data byte |
| legacy_wr_block | output | 1 | 1 = legacy decoder must ignore the current write |
| wide_mode | output | 1 | Current mode bit (1 = wide) |
| regs_flat | output | 256 | Sixteen 16-bit registers, register k in bits [16k+15:16k] |

## Verification
The single write port into the bank has to serve two things that can fall on one bus-cycle end: committing a held first byte as a low-byte write, and taking in a fresh window write that becomes the new held byte. The mode bit can also change at the same moment a held byte is flushed. The bench provokes these cases with a write followed by a write two addresses higher, a repeated write to the same address, a descending pair, and a mode-clear write while a byte is held. After every bus cycle it compares all sixteen registers and the mode bit against an arithmetic model. The override line is sampled mid-cycle against the value that the pairing rule predicts.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   // Kind of update the register bank applies at the end of a bus cycle.
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_LOW  = 2'd1,
      WR_WIDE = 2'd2
   } wr_kind_e;

endpackage

// File: rtl/wpc_bus_sampler.sv
module wpc_bus_sampler #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_e,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              cyc_end,
   output logic              cyc_write,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [DATA_W-1:0] cyc_data
);

   logic e_q;

   // Capture the cycle while E is high so that bus changes after the
   // strobe drops cannot disturb the decision taken at the edge.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q       <= 1'b0;
         cyc_write <= 1'b0;
         cyc_addr  <= '0;
         cyc_data  <= '0;
      end else begin
         e_q <= bus_e;
         if (bus_e) begin
            cyc_write <= ~bus_rnw;
            cyc_addr  <= bus_addr;
            cyc_data  <= bus_wdata;
         end
      end
   end

   assign cyc_end = e_q & ~bus_e;

endmodule

// File: rtl/wpc_pair_tracker.sv
module wpc_pair_tracker
   import wpc_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              DATA_W    = 8,
   parameter int              NUM_REGS  = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFFA0,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFEF,
   parameter int              MODE_BIT  = 0,
   localparam int             IDX_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_end,
   input  logic              cyc_write,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [DATA_W-1:0] cyc_data,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              mode_wide,
   output logic              steal,
   output wr_kind_e          wr_kind,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_hi,
   output logic [DATA_W-1:0] wr_lo
);

   logic              pend_v;
   logic [IDX_W-1:0]  pend_idx;
   logic [ADDR_W-1:0] pend_next;
   logic [DATA_W-1:0] pend_byte;

   logic cyc_in_win;
   logic cyc_is_mode;
   logic pair_hit;

   assign cyc_in_win  = (cyc_addr[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
   assign cyc_is_mode = (cyc_addr == MODE_ADDR);
   assign pair_hit    = pend_v & cyc_write & (cyc_addr == pend_next);

   // Live override: the second write of a pair is in flight.
   assign steal = pend_v & ~bus_rnw & (bus_addr == pend_next);

   always_comb begin
      wr_kind = WR_NONE;
      if (cyc_end) begin
         if (pair_hit)
            wr_kind = WR_WIDE;
         else if (pend_v)
            wr_kind = WR_LOW;
         else if (cyc_write && cyc_in_win && !mode_wide)
            wr_kind = WR_LOW;
      end
   end

   assign wr_idx = pend_v ? pend_idx : cyc_addr[IDX_W-1:0];
   assign wr_hi  = pend_byte;
   assign wr_lo  = (pend_v && !pair_hit) ? pend_byte : cyc_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_next <= '0;
         pend_byte <= '0;
         mode_wide <= 1'b0;
      end else if (cyc_end) begin
         pend_v <= 1'b0;
         if (!pair_hit) begin
            if (cyc_write && cyc_is_mode) begin
               mode_wide <= cyc_data[MODE_BIT];
            end else if (cyc_write && cyc_in_win && mode_wide) begin
               pend_v    <= 1'b1;
               pend_idx  <= cyc_addr[IDX_W-1:0];
               pend_next <= cyc_addr + ADDR_W'(1);
               pend_byte <= cyc_data;
            end
         end
      end
   end

endmodule

// File: rtl/wpc_reg_bank.sv
module wpc_reg_bank
   import wpc_pkg::*;
#(
   parameter int  DATA_W   = 8,
   parameter int  NUM_REGS = 16,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int REG_W    = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  wr_kind_e                  wr_kind,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]         wr_hi,
   input  logic [DATA_W-1:0]         wr_lo,
   output logic [NUM_REGS*REG_W-1:0] regs_flat
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] hi_q;
      logic [DATA_W-1:0] lo_q;
      logic              sel;

      assign sel = (wr_kind != WR_NONE) && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else if (sel) begin
            lo_q <= wr_lo;
            if (wr_kind == WR_WIDE)
               hi_q <= wr_hi;
         end
      end

      assign regs_flat[g*REG_W +: REG_W] = {hi_q, lo_q};
   end

endmodule

// File: rtl/wide_pair_capture.sv
module wide_pair_capture
   import wpc_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                NUM_REGS  = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFFA0,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFEF,
   parameter int                MODE_BIT  = 0,
   localparam int               IDX_W     = $clog2(NUM_REGS),
   localparam int               REG_W     = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_e,
   input  logic                      bus_rnw,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic                      legacy_wr_block,
   output logic                      wide_mode,
   output logic [NUM_REGS*REG_W-1:0] regs_flat
);

   localparam int WIN_LAST_NEXT = int'(WIN_BASE) + NUM_REGS;

   // Elaboration-time parameter checks
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_count
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if ((int'(WIN_BASE) % NUM_REGS) != 0) begin : g_bad_align
      $error("WIN_BASE must be aligned to NUM_REGS");
   end
   if (int'(MODE_ADDR) >= int'(WIN_BASE) && int'(MODE_ADDR) <= WIN_LAST_NEXT) begin : g_bad_mode
      $error("MODE_ADDR must lie outside the window and its spill address");
   end
   if (MODE_BIT < 0 || MODE_BIT >= DATA_W) begin : g_bad_bit
      $error("MODE_BIT must index the data byte");
   end

   logic              cyc_end;
   logic              cyc_write;
   logic [ADDR_W-1:0] cyc_addr;
   logic [DATA_W-1:0] cyc_data;
   wr_kind_e          wr_kind;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_hi;
   logic [DATA_W-1:0] wr_lo;

   wpc_bus_sampler #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_e     (bus_e),
      .bus_rnw   (bus_rnw),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cyc_end   (cyc_end),
      .cyc_write (cyc_write),
      .cyc_addr  (cyc_addr),
      .cyc_data  (cyc_data)
   );

   wpc_pair_tracker #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .WIN_BASE  (WIN_BASE),
      .MODE_ADDR (MODE_ADDR),
      .MODE_BIT  (MODE_BIT)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_end   (cyc_end),
      .cyc_write (cyc_write),
      .cyc_addr  (cyc_addr),
      .cyc_data  (cyc_data),
      .bus_rnw   (bus_rnw),
      .bus_addr  (bus_addr),
      .mode_wide (wide_mode),
      .steal     (legacy_wr_block),
      .wr_kind   (wr_kind),
      .wr_idx    (wr_idx),
      .wr_hi     (wr_hi),
      .wr_lo     (wr_lo)
   );

   wpc_reg_bank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_kind   (wr_kind),
      .wr_idx    (wr_idx),
      .wr_hi     (wr_hi),
      .wr_lo     (wr_lo),
      .regs_flat (regs_flat)
   );

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int                ADDR_W   = 16,
   parameter int                NUM_REGS = 16,
   parameter int                REG_W    = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFFA0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_e,
   input logic                      bus_rnw,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic                      legacy_wr_block,
   input logic                      wide_mode,
   input logic [NUM_REGS*REG_W-1:0] regs_flat
);

   localparam logic [ADDR_W-1:0] SPILL_ADDR = WIN_BASE + ADDR_W'(NUM_REGS);

   logic e_seen;
   logic e_fell;

   always_ff @(posedge clk) begin
      if (!rst_n) e_seen <= 1'b0;
      else        e_seen <= bus_e;
   end

   assign e_fell = e_seen & ~bus_e;

   AST_COMPAT_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> !legacy_wr_block); // R2

   AST_STEAL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_wr_block |-> !bus_rnw); // R5

   AST_STEAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_wr_block |-> (bus_addr > WIN_BASE && bus_addr <= SPILL_ADDR)); // R6

   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !e_fell |=> $stable(regs_flat)); // R9

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !e_fell |=> $stable(wide_mode)); // R3

endmodule

bind wide_pair_capture wpc_checker #(
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS),
   .REG_W    (REG_W),
   .WIN_BASE (WIN_BASE)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bus_e           (bus_e),
   .bus_rnw         (bus_rnw),
   .bus_addr        (bus_addr),
   .legacy_wr_block (legacy_wr_block),
   .wide_mode       (wide_mode),
   .regs_flat       (regs_flat)
);

// File: tb/wide_pair_capture_tb_top.sv
module wide_pair_capture_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 16;
   localparam logic [15:0] BASE  = 16'hFFA0;
   localparam logic [15:0] MADDR = 16'hFFEF;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_e;
   logic          bus_rnw;
   logic [15:0]   bus_addr;
   logic [7:0]    bus_wdata;
   logic          legacy_wr_block;
   logic          wide_mode;
   logic [255:0]  regs_flat;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Reference state derived from the requirements
   logic [15:0] m_reg [NREG];
   logic        m_mode;
   logic        m_pv;
   int          m_pidx;
   logic [15:0] m_pnext;
   logic [7:0]  m_pbyte;

   always #(CLK_PERIOD/2) clk = ~clk;

   wide_pair_capture dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .bus_e           (bus_e),
      .bus_rnw         (bus_rnw),
      .bus_addr        (bus_addr),
      .bus_wdata       (bus_wdata),
      .legacy_wr_block (legacy_wr_block),
      .wide_mode       (wide_mode),
      .regs_flat       (regs_flat)
   );

   function automatic logic [255:0] model_flat();
      logic [255:0] f;
      for (int i = 0; i < NREG; i++) f[i*16 +: 16] = m_reg[i];
      return f;
   endfunction

   task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [15:0] a);
      return (a >= BASE) && (a < BASE + 16'(NREG));
   endfunction

   // One bus cycle with the reference update applied at its end.
   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                            input logic rnw, input string tag);
      logic exp_steal;
      logic stolen;
      exp_steal = m_pv && !rnw && (a == m_pnext);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_rnw   = rnw;
      bus_e     = 1'b1;
      repeat (2) @(negedge clk);
      check({tag, " override"}, 256'(legacy_wr_block), 256'(exp_steal));
      bus_e = 1'b0;
      repeat (2) @(negedge clk);
      // reference update
      stolen = 1'b0;
      if (m_pv) begin
         if (!rnw && a == m_pnext) begin
            m_reg[m_pidx] = {m_pbyte, d};
            stolen = 1'b1;
         end else begin
            m_reg[m_pidx][7:0] = m_pbyte;
         end
         m_pv = 1'b0;
      end
      if (!stolen && !rnw) begin
         if (a == MADDR) begin
            m_mode = d[0];
         end else if (in_win(a)) begin
            if (m_mode) begin
               m_pv    = 1'b1;
               m_pidx  = int'(a - BASE);
               m_pnext = a + 16'd1;
               m_pbyte = d;
            end else begin
               m_reg[int'(a - BASE)][7:0] = d;
            end
         end
      end
      check({tag, " regs"}, regs_flat, model_flat());
      check({tag, " mode"}, 256'(wide_mode), 256'(m_mode));
      bus_rnw = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NREG; i++) m_reg[i] = 16'h0000;
      m_mode = 1'b0; m_pv = 1'b0; m_pidx = 0; m_pnext = 16'h0; m_pbyte = 8'h0;
      rst_n = 1'b0; bus_e = 1'b0; bus_rnw = 1'b1; bus_addr = 16'h0; bus_wdata = 8'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset contents; R3: reset mode
      check("R9 reset regs", regs_flat, 256'h0);
      check("R3 reset mode", 256'(wide_mode), 256'h0);
      check("R2 reset override", 256'(legacy_wr_block), 256'h0);

      // R2: compatible byte writes across the window
      for (int i = 0; i < NREG; i++)
         bus_cycle(BASE + 16'(i), 8'(8'h10 + i * 3), 1'b0, "R2 compat byte");
      bus_cycle(16'hFFA4, 8'hC4, 1'b0, "R2 compat adjacent first");
      bus_cycle(16'hFFA5, 8'hC5, 1'b0, "R2 compat adjacent second");
      // R1: outside writes and reads
      bus_cycle(16'hFF9F, 8'hEE, 1'b0, "R1 below window");
      bus_cycle(16'hFFB0, 8'hEE, 1'b0, "R1 above window");
      bus_cycle(16'hFFA2, 8'hEE, 1'b1, "R1 read window");

      // R3: enter wide mode
      bus_cycle(MADDR, 8'h01, 1'b0, "R3 set wide");

      // R4, R5, R6: pair sweep, last pair crosses into the spill address
      for (int i = 0; i < NREG; i++) begin
         bus_cycle(BASE + 16'(i),     8'(8'hA0 ^ i), 1'b0, "R4 pair first");
         bus_cycle(BASE + 16'(i + 1), 8'(8'h50 + i), 1'b0, (i == NREG-1) ? "R6 pair spill" : "R5 pair second");
      end

      // R7: unpaired first byte variants
      bus_cycle(16'hFFA3, 8'h33, 1'b0, "R7 first");
      bus_cycle(16'hFFA4, 8'h44, 1'b1, "R5 R7 read next addr");
      bus_cycle(16'hFFA5, 8'h55, 1'b0, "R7 first");
      bus_cycle(16'hFFA7, 8'h77, 1'b0, "R7 skip address");
      bus_cycle(16'hFFA8, 8'h88, 1'b0, "R4 pair after skip");
      bus_cycle(16'hFFA9, 8'h99, 1'b0, "R7 first");
      bus_cycle(16'hFFA9, 8'h9A, 1'b0, "R7 same address");
      bus_cycle(16'hFFAB, 8'hBB, 1'b0, "R7 descending first");
      bus_cycle(16'hFFAA, 8'hAA, 1'b0, "R7 descending second");
      bus_cycle(16'hFF00, 8'h00, 1'b1, "R7 flush by read");
      bus_cycle(16'hFFAC, 8'hCC, 1'b0, "R7 first");
      bus_cycle(16'hFF10, 8'h12, 1'b0, "R7 outside write");

      // R8: back-to-back pairs do not chain
      bus_cycle(16'hFFA0, 8'h01, 1'b0, "R8 pair A first");
      bus_cycle(16'hFFA1, 8'h02, 1'b0, "R8 pair A second");
      bus_cycle(16'hFFA2, 8'h03, 1'b0, "R8 pair B first");
      bus_cycle(16'hFFA3, 8'h04, 1'b0, "R8 pair B second");
      bus_cycle(16'hFFA4, 8'h05, 1'b1, "R8 idle read");

      // R3 with R7: mode cleared while a byte is held
      bus_cycle(16'hFFA6, 8'h66, 1'b0, "R7 held before mode");
      bus_cycle(MADDR, 8'h00, 1'b0, "R3 clear wide");
      bus_cycle(16'hFFA6, 8'hD6, 1'b0, "R2 compat after clear");
      bus_cycle(16'hFFA7, 8'hD7, 1'b0, "R2 compat adjacent");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule